// File: doc/BRIEF.md
# Maskable Time-of-Day Alarm Unit

This block holds two programmable alarms against a running BCD calendar. Each time a one-second update strobe arrives, it compares the current time with both alarms. When an alarm matches, the block sets that alarm's flag, and the flag stays set until software clears it.

The first alarm compares seconds, minutes, hours and a day field. The second alarm compares minutes, hours and a day field, and it is checked only at the top of each minute. A mask bit in each alarm field turns that field into a don't-care. Setting masks therefore gives repeat rates from once a second up to once per weekday or date.

A single active-low output pin is shared between two uses. When alarm routing is selected, the pin goes low while any enabled flag is set. Otherwise the pin carries a square-wave source supplied from outside. The timekeeping counter and the register bus are outside this block.

Top module: `tod_alarm_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both alarm flags read 0.
- R2: A flag is set only at a clock edge where `tick` is 1. Without `tick`, a match sets nothing.
- R3: Alarm 1 matches when every field without a mask agrees. The seconds, minutes and hours fields use bit 7 as the mask and bits 6:0 as the value, compared with `now_sec`, `now_min` and `now_hr`. With all four masks set, alarm 1 fires on every tick.
- R4: In a day field, bit 7 is the mask. When bit 6 is 1, bits 2:0 are compared with `now_wday`. When bit 6 is 0, bits 5:0 are compared with `now_mday`.
- R5: Alarm 2 compares minutes, hours and the day field in the same way as alarm 1. It can match only on a tick where `now_sec` is 0.
- R6: The flags are sticky. A cycle with `flag_we`=1 clears each flag whose bit in `flag_wdata` is 0, and leaves a flag alone when its bit is 1. Bit 0 belongs to alarm 1 and bit 1 to alarm 2.
- R7: If a clear and a match reach the same flag at the same edge, the flag is set.
- R8: Flags are set whatever the values of `intcn`, `a1_ie` and `a2_ie`.
- R9: With `intcn`=1, `irq_sqw_n` is 0 exactly when (`a1_flag` and `a1_ie`) or (`a2_flag` and `a2_ie`). Otherwise it is 1.
- R10: With `intcn`=0, `irq_sqw_n` follows `sqw_in`, and the alarm flags do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second update strobe |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hr | input | 7 | Current hours register, BCD plus mode bits |
| now_wday | input | 3 | Day of week, 1 to 7 |
| now_mday | input | 6 | Date of month, BCD |
| a1_sec | input | 8 | Alarm 1 seconds: mask bit 7, value bits 6:0 |
| a1_min | input | 8 | Alarm 1 minutes: mask bit 7, value bits 6:0 |
| a1_hr | input | 8 | Alarm 1 hours: mask bit 7, value bits 6:0 |
| a1_day | input | 8 | Alarm 1 day: mask bit 7, select bit 6, value |
| a2_min | input | 8 | Alarm 2 minutes |
| a2_hr | input | 8 | Alarm 2 hours |
| a2_day | input | 8 | Alarm 2 day |
| intcn | input | 1 | 1 routes alarms to the pin, 0 routes the square wave |
| a1_ie | input | 1 | Alarm 1 interrupt enable |
| a2_ie | input | 1 | Alarm 2 interrupt enable |
| sqw_in | input | 1 | Square-wave source |
| flag_we | input | 1 | Flag register write strobe |
| flag_wdata | input | 2 | Write data: 0 clears, 1 keeps |
| a1_flag | output | 1 | Alarm 1 flag |
| a2_flag | output | 1 | Alarm 2 flag |
| irq_sqw_n | output | 1 | Shared interrupt / square-wave pin |

## Verification
A flag changes at the clock edge that samples `tick`, or that samples a flag write. The new value is visible on the next falling edge. The pin level depends combinationally on the flags, the control bits and `sqw_in`. It therefore settles in the same cycle as the flags, and it follows `sqw_in` with no delay. The reference model advances its flags at each rising edge, from the inputs that were held across that edge. All three outputs are compared at the following falling edge, so every result is checked in the cycle it is due.

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [6:0] now_sec,
  input  logic [6:0] now_min,
  input  logic [6:0] now_hr,
  input  logic [2:0] now_wday,
  input  logic [5:0] now_mday,
  input  logic [7:0] a1_sec,
  input  logic [7:0] a1_min,
  input  logic [7:0] a1_hr,
  input  logic [7:0] a1_day,
  input  logic [7:0] a2_min,
  input  logic [7:0] a2_hr,
  input  logic [7:0] a2_day,
  input  logic       intcn,
  input  logic       a1_ie,
  input  logic       a2_ie,
  input  logic       sqw_in,
  input  logic       flag_we,
  input  logic [1:0] flag_wdata,
  output logic       a1_flag,
  output logic       a2_flag,
  output logic       irq_sqw_n
);

  function automatic logic fld_ok(input logic [7:0] f, input logic [6:0] cur);
    return f[7] | (f[6:0] == cur);
  endfunction

  function automatic logic day_ok(input logic [7:0] f, input logic [2:0] wd,
                                  input logic [5:0] md);
    return f[7] | (f[6] ? (f[2:0] == wd) : (f[5:0] == md));
  endfunction

  logic hit1, hit2, nxt1, nxt2, irq_act;

  assign hit1 = fld_ok(a1_sec, now_sec) & fld_ok(a1_min, now_min) &
                fld_ok(a1_hr, now_hr) & day_ok(a1_day, now_wday, now_mday);

  assign hit2 = (now_sec == 7'h00) & fld_ok(a2_min, now_min) &
                fld_ok(a2_hr, now_hr) & day_ok(a2_day, now_wday, now_mday);

  assign nxt1 = (tick & hit1) | (a1_flag & ~(flag_we & ~flag_wdata[0]));
  assign nxt2 = (tick & hit2) | (a2_flag & ~(flag_we & ~flag_wdata[1]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a1_flag <= 1'b0;
      a2_flag <= 1'b0;
    end else begin
      a1_flag <= nxt1;
      a2_flag <= nxt2;
    end
  end

  assign irq_act   = (a1_flag & a1_ie) | (a2_flag & a2_ie);
  assign irq_sqw_n = intcn ? ~irq_act : sqw_in;

endmodule

module tod_alarm_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [6:0] now_sec,
  input logic       intcn,
  input logic       flag_we,
  input logic [1:0] flag_wdata,
  input logic       a1_flag,
  input logic       a2_flag,
  input logic       irq_sqw_n
);

  a_r2_no_set_a1_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !$rose(a1_flag));

  a_r2_no_set_a2_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !$rose(a2_flag));

  a_r5_a2_only_at_sec_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && now_sec != 7'h00) |=> !$rose(a2_flag));

  a_r6_sticky_a1: assert property (@(posedge clk) disable iff (!rst_n)
    (a1_flag && !flag_we) |=> a1_flag);

  a_r6_clear_a1: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !flag_wdata[0] && !tick) |=> !a1_flag);

  a_r6_clear_a2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !flag_wdata[1] && !tick) |=> !a2_flag);

  a_r9_low_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (intcn && !irq_sqw_n) |-> (a1_flag || a2_flag));

endmodule

bind tod_alarm_unit tod_alarm_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .now_sec(now_sec), .intcn(intcn),
  .flag_we(flag_we), .flag_wdata(flag_wdata), .a1_flag(a1_flag),
  .a2_flag(a2_flag), .irq_sqw_n(irq_sqw_n)
);

// File: tb/tod_alarm_unit_bench.sv
module tod_alarm_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, tick = 0;
  logic [6:0] now_sec = 0, now_min = 0, now_hr = 0;
  logic [2:0] now_wday = 1;
  logic [5:0] now_mday = 6'h01;
  logic [7:0] a1_sec = 0, a1_min = 0, a1_hr = 0, a1_day = 0;
  logic [7:0] a2_min = 0, a2_hr = 0, a2_day = 0;
  logic intcn = 1, a1_ie = 0, a2_ie = 0, sqw_in = 0, flag_we = 0;
  logic [1:0] flag_wdata = 2'b11;
  logic a1_flag, a2_flag, irq_sqw_n;

  int vectors = 0, miscompares = 0;
  bit ref1 = 0, ref2 = 0;
  string req = "R1";

  tod_alarm_unit u_tod_alarm_unit (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] bcd(input int v);
    return 7'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int val(input logic [6:0] b);
    return int'(b[6:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic bit num_eq(input logic [7:0] f, input logic [6:0] cur);
    if (f[7]) return 1;
    return val(f[6:0]) == val(cur) && f[6:0] == cur;
  endfunction

  function automatic bit day_eq(input logic [7:0] f);
    if (f[7]) return 1;
    if (f[6]) return int'(f[2:0]) == int'(now_wday);
    return f[5:0] == now_mday;
  endfunction

  task automatic check(input string name, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, name, act, exp, $time);
    end
  endtask

  task automatic cyc();
    bit n1, n2, en;
    n1 = ref1; n2 = ref2;
    if (flag_we && !flag_wdata[0]) n1 = 0;
    if (flag_we && !flag_wdata[1]) n2 = 0;
    if (tick && num_eq(a1_sec, now_sec) && num_eq(a1_min, now_min) &&
        num_eq(a1_hr, now_hr) && day_eq(a1_day)) n1 = 1;
    if (tick && val(now_sec) == 0 && num_eq(a2_min, now_min) &&
        num_eq(a2_hr, now_hr) && day_eq(a2_day)) n2 = 1;
    if (!rst_n) begin n1 = 0; n2 = 0; end
    @(posedge clk);
    ref1 = n1; ref2 = n2;
    @(negedge clk);
    check("a1_flag", a1_flag, ref1);
    check("a2_flag", a2_flag, ref2);
    en = (ref1 && a1_ie) || (ref2 && a2_ie);
    check("irq_sqw_n", irq_sqw_n, intcn ? !en : sqw_in);
  endtask

  task automatic set_time(input int s, input int m, input int h);
    now_sec = bcd(s); now_min = bcd(m); now_hr = bcd(h);
  endtask

  task automatic tick_once();
    tick = 1; cyc(); tick = 0;
  endtask

  task automatic clear_all();
    flag_we = 1; flag_wdata = 2'b00; cyc(); flag_we = 0; flag_wdata = 2'b11;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    req = "R1";
    repeat (3) cyc();
    rst_n = 1;
    cyc();

    req = "R2";
    set_time(15, 30, 8);
    a1_sec = {1'b0, bcd(15)}; a1_min = {1'b0, bcd(30)}; a1_hr = {1'b0, bcd(8)};
    a1_day = 8'h80;
    repeat (4) cyc();
    tick_once();
    cyc();

    req = "R3";
    clear_all();
    a1_day = 8'h00 | 8'h01;
    now_mday = 6'h01;
    tick_once();
    clear_all();
    now_min = bcd(31);
    tick_once();
    a1_min = 8'h80;
    tick_once();
    clear_all();
    a1_sec = 8'h80; a1_hr = 8'h80; a1_day = 8'h80;
    for (int i = 0; i < 3; i++) begin
      set_time(i * 7, i, i);
      tick_once();
      clear_all();
    end

    req = "R4";
    a1_sec = 8'h80; a1_min = 8'h80; a1_hr = 8'h80;
    a1_day = 8'h40 | 8'h05;
    now_wday = 3'd4; now_mday = 6'h05;
    tick_once();
    now_wday = 3'd5;
    tick_once();
    clear_all();
    a1_day = 8'h00 | 8'h25;
    tick_once();
    now_mday = 6'h25;
    tick_once();
    clear_all();

    req = "R5";
    a1_day = 8'h80; a1_ie = 0;
    a2_min = {1'b0, bcd(45)}; a2_hr = {1'b0, bcd(12)}; a2_day = 8'h80;
    set_time(30, 45, 12);
    tick_once();
    set_time(0, 45, 12);
    tick_once();
    clear_all();
    set_time(0, 46, 12);
    tick_once();

    req = "R6";
    set_time(0, 45, 12);
    tick_once();
    repeat (3) cyc();
    flag_we = 1; flag_wdata = 2'b01; cyc();
    flag_wdata = 2'b10; cyc();
    flag_we = 0; flag_wdata = 2'b11;
    tick_once();
    flag_we = 1; flag_wdata = 2'b11; cyc(); flag_we = 0;

    req = "R7";
    flag_we = 1; flag_wdata = 2'b00; tick = 1; cyc();
    tick = 0; flag_we = 0; flag_wdata = 2'b11;
    cyc();
    clear_all();

    req = "R8";
    intcn = 0; a1_ie = 0; a2_ie = 0;
    tick_once();
    cyc();

    req = "R9";
    intcn = 1;
    cyc();
    a1_ie = 1; cyc();
    a2_ie = 1; cyc();
    flag_we = 1; flag_wdata = 2'b10; cyc();
    flag_wdata = 2'b01; cyc(); flag_we = 0; flag_wdata = 2'b11;
    a1_ie = 0; cyc();

    req = "R10";
    tick_once();
    intcn = 0;
    for (int i = 0; i < 8; i++) begin
      sqw_in = i[0]; cyc();
    end
    clear_all();
    for (int i = 0; i < 4; i++) begin
      sqw_in = i[1]; cyc();
    end
    intcn = 1; sqw_in = 0;

    req = "R3";
    a1_sec = 8'h80; a1_min = {1'b0, bcd(2)}; a1_hr = 8'h80; a1_day = 8'h80;
    a2_min = 8'h80; a2_hr = 8'h80; a2_day = 8'h00 | 8'h25;
    a1_ie = 1; a2_ie = 1;
    begin
      int s, m;
      s = 50; m = 1;
      for (int i = 0; i < 300; i++) begin
        req = (s == 0) ? "R5" : "R3";
        set_time(s, m, 9);
        tick_once();
        if (i % 7 == 6) begin
          req = "R6";
          flag_we = 1; flag_wdata = 2'(i % 4);
        end
        cyc();
        flag_we = 0; flag_wdata = 2'b11;
        s++;
        if (s == 60) begin s = 0; m = (m + 1) % 60; end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule